// File: doc/BRIEF.md
# I2C Slave Transmitter with Status Codes

This block is the read side of an I2C target device. It watches the open-drain SCL and SDA lines through synchronisers and waits for a START. It then collects the address byte and answers only when the byte carries its own 7-bit address and a read direction bit. It shifts data bytes out MSB first and samples the master's acknowledge on the ninth clock.

Each step is handed to software. At every point where a decision is needed, the block raises an interrupt flag and places an 8-bit status code in a status register. While the flag is up, it holds SCL low. Software reads the code, loads the next byte, chooses the acknowledge-enable bit and clears the flag. The block then releases SCL and the transfer continues.

If the acknowledge-enable bit is low when a byte is released, that byte is the last one. After it, the block leaves the bus and the master reads only ones until the next START or STOP. An arbitration-lost input marks the next successful read address so that it reports a separate code.

Top module: `i2c_slave_tx`

## Requirements
- R1: After reset the flag `si_o` is 0, `status_o` is 0xF8, and neither `scl_oe` nor `sda_oe` is asserted.
- R2: An address byte whose upper seven bits equal `own_addr` and whose bit 0 is 1 (read), received while `aa_i` is 1, is acknowledged: SDA is low during the ninth clock. On the ninth SCL falling edge `si_o` goes to 1 and `status_o` to 0xA8.
- R3: An address byte with a different address, or with bit 0 equal to 0 (write), is not acknowledged. `si_o` stays 0 and SDA is never driven for the rest of that transfer.
- R4: While `aa_i` is 0, the block does not acknowledge its own read address and does not raise `si_o`. Once `aa_i` is 1 again, the next own read address is acknowledged.
- R5: After a pulse on `arb_lost_i`, the next acknowledged own read address reports `status_o` = 0xB0 instead of 0xA8.
- R6: While `si_o` is 1, `scl_oe` holds SCL low. A `si_clr` pulse clears `si_o` on the next cycle, and SCL is released after one further cycle.
- R7: A data byte is taken from the value last written through `data_we`/`data_wr` and is sent MSB first. SDA changes only while SCL is low.
- R8: The master's acknowledge is sampled on the ninth SCL rising edge. An ACK on a byte that is not the last gives `status_o` = 0xB8, and the block then sends the next byte.
- R9: A NACK on any data byte gives `status_o` = 0xC0. After `si_clr` the block releases SDA, and any further byte the master clocks reads as 0xFF.
- R10: A byte released while `aa_i` is 0 is the last byte. An ACK on it gives `status_o` = 0xC8, and bytes clocked after it read as 0xFF.
- R11: A STOP returns the block to idle. A repeated START restarts address recognition from any state other than the stretch phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| own_addr | input | 7 | Own 7-bit target address |
| data_wr | input | 8 | Byte to transmit |
| data_we | input | 1 | Loads `data_wr` into the data register |
| aa_i | input | 1 | Acknowledge enable; 0 marks the next released byte as the last |
| si_clr | input | 1 | Pulse that clears the interrupt flag |
| arb_lost_i | input | 1 | Pulse: arbitration was lost as master |
| si_o | output | 1 | Interrupt flag |
| status_o | output | 8 | Status code |

## Verification
Every result that depends on the bus appears a fixed delay after the SCL edge that causes it. The delay is `SYNC_STAGES` synchroniser cycles, one edge-detect cycle and one register cycle: four clocks with the defaults. The bench always waits ten clocks after a falling edge before it reads `si_o` and `status_o`. It reads SDA in the middle of each SCL high phase, so the acknowledge bit and the data bits are already settled. The `si_clr` and SCL-release effects are checked on the cycle after the pulse and after the master has seen SCL go high.

// File: rtl/i2c_stx_pkg.sv
package i2c_stx_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [3:0] {
        ST_IDLE,      // waiting for START
        ST_ADDR,      // shifting in the address byte
        ST_MATCH,     // own read address seen, waiting for SCL low
        ST_ADDR_ACK,  // pulling SDA low for the address ACK
        ST_TX,        // driving data bits
        ST_TX_ACK,    // SDA released, master acknowledges
        ST_HOLD,      // SI set, SCL stretched
        ST_LOAD,      // first data bit set up, SCL still held
        ST_DETACH     // not addressed, ignoring the bus
    } stx_state_e;

    localparam logic [7:0] SC_NONE      = 8'hF8;
    localparam logic [7:0] SC_ADDR_ACK  = 8'hA8;
    localparam logic [7:0] SC_ARB_ADDR  = 8'hB0;
    localparam logic [7:0] SC_DATA_ACK  = 8'hB8;
    localparam logic [7:0] SC_DATA_NACK = 8'hC0;
    localparam logic [7:0] SC_LAST_ACK  = 8'hC8;

endpackage

// File: rtl/i2c_stx_busmon.sv
module i2c_stx_busmon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_sync [SYNC_STAGES];
    logic sda_sync [SYNC_STAGES];
    logic scl_d, sda_d, scl_s;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sync[g] <= 1'b1;
                    sda_sync[g] <= 1'b1;
                end else begin
                    scl_sync[g] <= scl_i;
                    sda_sync[g] <= sda_i;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sync[g] <= 1'b1;
                    sda_sync[g] <= 1'b1;
                end else begin
                    scl_sync[g] <= scl_sync[g-1];
                    sda_sync[g] <= sda_sync[g-1];
                end
            end
        end
    end

    assign scl_s = scl_sync[SYNC_STAGES-1];
    assign sda_s = sda_sync[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_stx_fsm.sv
module i2c_stx_fsm
    import i2c_stx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sda_s,
    input  logic                 scl_rise,
    input  logic                 scl_fall,
    input  logic                 start_det,
    input  logic                 stop_det,
    input  logic [ADDR_W-1:0]    own_addr,
    input  logic [BYTE_W-1:0]    data_wr,
    input  logic                 data_we,
    input  logic                 aa_i,
    input  logic                 si_clr,
    input  logic                 arb_lost_i,
    output logic                 si_o,
    output logic [7:0]           status_o,
    output logic                 sda_oe,
    output logic                 scl_oe,
    output stx_state_e           state_o
);

    stx_state_e          state_q, state_d;
    logic [CNT_W-1:0]    cnt_q;
    logic [BYTE_W-1:0]   sh_q, data_q, addr_byte;
    logic                last_q, ack_q, go_tx_q, arb_q, si_q;
    logic [7:0]          status_q;
    logic                bus_live, byte_end, addr_hit;

    // START/STOP are acted on everywhere except while SCL is stretched
    assign bus_live  = (state_q != ST_HOLD) && (state_q != ST_LOAD);
    assign byte_end  = (cnt_q == CNT_W'(BYTE_W - 1));
    assign addr_byte = {sh_q[BYTE_W-2:0], sda_s};
    assign addr_hit  = (addr_byte[BYTE_W-1:1] == own_addr) && addr_byte[0] && aa_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (bus_live && stop_det) begin
            state_d = ST_IDLE;
        end else if (bus_live && start_det) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DETACH: state_d = state_q;
                ST_ADDR:     if (scl_rise && byte_end) state_d = addr_hit ? ST_MATCH : ST_DETACH;
                ST_MATCH:    if (scl_fall) state_d = ST_ADDR_ACK;
                ST_ADDR_ACK: if (scl_fall) state_d = ST_HOLD;
                ST_TX:       if (scl_fall && byte_end) state_d = ST_TX_ACK;
                ST_TX_ACK:   if (scl_fall) state_d = ST_HOLD;
                ST_HOLD:     if (si_clr) state_d = go_tx_q ? ST_LOAD : ST_DETACH;
                ST_LOAD:     state_d = ST_TX;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // datapath, flag and status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            sh_q     <= '0;
            data_q   <= '0;
            last_q   <= 1'b0;
            ack_q    <= 1'b0;
            go_tx_q  <= 1'b0;
            arb_q    <= 1'b0;
            si_q     <= 1'b0;
            status_q <= SC_NONE;
        end else begin
            if (data_we) data_q <= data_wr;
            if (bus_live && stop_det) begin
                arb_q <= 1'b0;
            end else if (bus_live && start_det) begin
                cnt_q <= '0;
            end else begin
                unique case (state_q)
                    ST_ADDR: if (scl_rise) begin
                        sh_q  <= addr_byte;
                        cnt_q <= cnt_q + 1'b1;
                        if (byte_end && !addr_hit) arb_q <= 1'b0;
                    end
                    ST_ADDR_ACK: if (scl_fall) begin
                        si_q     <= 1'b1;
                        status_q <= arb_q ? SC_ARB_ADDR : SC_ADDR_ACK;
                        go_tx_q  <= 1'b1;
                        arb_q    <= 1'b0;
                    end
                    ST_TX: if (scl_fall) begin
                        sh_q  <= {sh_q[BYTE_W-2:0], 1'b1};
                        cnt_q <= cnt_q + 1'b1;
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) ack_q <= ~sda_s;
                        if (scl_fall) begin
                            si_q <= 1'b1;
                            if (!ack_q) begin
                                status_q <= SC_DATA_NACK;
                                go_tx_q  <= 1'b0;
                            end else if (last_q) begin
                                status_q <= SC_LAST_ACK;
                                go_tx_q  <= 1'b0;
                            end else begin
                                status_q <= SC_DATA_ACK;
                                go_tx_q  <= 1'b1;
                            end
                        end
                    end
                    ST_HOLD: if (si_clr) begin
                        si_q <= 1'b0;
                        if (go_tx_q) begin
                            sh_q   <= data_q;
                            cnt_q  <= '0;
                            last_q <= ~aa_i;
                        end
                    end
                    default: ;
                endcase
            end
            if (arb_lost_i) arb_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        sda_oe = 1'b0;
        scl_oe = 1'b0;
        unique case (state_q)
            ST_ADDR_ACK:     sda_oe = 1'b1;
            ST_TX:           sda_oe = ~sh_q[BYTE_W-1];
            ST_HOLD:         scl_oe = 1'b1;
            ST_LOAD: begin
                scl_oe = 1'b1;
                sda_oe = ~sh_q[BYTE_W-1];
            end
            default: ;
        endcase
    end

    assign si_o     = si_q;
    assign status_o = status_q;
    assign state_o  = state_q;

endmodule

// File: rtl/i2c_slave_tx.sv
module i2c_slave_tx
    import i2c_stx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        scl_oe,
    output logic        sda_oe,
    input  logic [6:0]  own_addr,
    input  logic [7:0]  data_wr,
    input  logic        data_we,
    input  logic        aa_i,
    input  logic        si_clr,
    input  logic        arb_lost_i,
    output logic        si_o,
    output logic [7:0]  status_o
);

    logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
    stx_state_e fsm_state;

    i2c_stx_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_busmon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_stx_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .own_addr   (own_addr),
        .data_wr    (data_wr),
        .data_we    (data_we),
        .aa_i       (aa_i),
        .si_clr     (si_clr),
        .arb_lost_i (arb_lost_i),
        .si_o       (si_o),
        .status_o   (status_o),
        .sda_oe     (sda_oe),
        .scl_oe     (scl_oe),
        .state_o    (fsm_state)
    );

endmodule

// File: rtl/i2c_stx_chk.sv
module i2c_stx_chk
    import i2c_stx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       si_o,
    input logic       si_clr,
    input logic [7:0] status_o,
    input stx_state_e fsm_state
);

    AST_SI_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        si_o |-> scl_oe); // R6

    AST_SI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (si_o && si_clr) |=> !si_o); // R6

    AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i); // R7

    AST_QUIET_DETACH: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_DETACH || fsm_state == ST_IDLE) |-> (!sda_oe && !scl_oe)); // R9

    AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(si_o) |-> (status_o == SC_ADDR_ACK || status_o == SC_ARB_ADDR ||
                         status_o == SC_DATA_ACK || status_o == SC_DATA_NACK ||
                         status_o == SC_LAST_ACK)); // R2

    AST_ADDR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(si_o) && $past(fsm_state) == ST_ADDR_ACK) |->
            (status_o == SC_ADDR_ACK || status_o == SC_ARB_ADDR)); // R5

endmodule

bind i2c_slave_tx i2c_stx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .si_o      (si_o),
    .si_clr    (si_clr),
    .status_o  (status_o),
    .fsm_state (fsm_state)
);

// File: tb/tb_i2c_slave_tx.sv
`timescale 1ns/1ps
module tb_i2c_slave_tx;

    localparam int HP = 20;
    localparam logic [6:0] OWN = 7'h52;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_oe, sda_oe, si_o;
    logic [7:0] status_o, data_wr = 8'h00;
    logic data_we = 1'b0, aa_i = 1'b1, si_clr = 1'b0, arb_lost_i = 1'b0;
    logic scl_line, sda_line;
    int   n_chk = 0, n_err = 0;
    bit   done = 1'b0;

    assign scl_line = scl_m & ~scl_oe;
    assign sda_line = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    i2c_slave_tx dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN),
        .data_wr(data_wr), .data_we(data_we), .aa_i(aa_i), .si_clr(si_clr),
        .arb_lost_i(arb_lost_i), .si_o(si_o), .status_o(status_o)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bit_xfer(input logic b, output logic rb);
        sda_m = b;
        tick(HP);
        scl_m = 1'b1;
        tick(1);
        while (!scl_line) tick(1);
        tick(HP / 2);
        rb = sda_line;
        tick(HP / 2);
        scl_m = 1'b0;
        tick(HP / 2);
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        tick(HP);
        scl_m = 1'b1;
        while (!scl_line) tick(1);
        tick(HP);
        sda_m = 1'b0;
        tick(HP);
        scl_m = 1'b0;
        tick(HP);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        tick(HP);
        scl_m = 1'b1;
        while (!scl_line) tick(1);
        tick(HP);
        sda_m = 1'b1;
        tick(HP);
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ackbit);
        logic rb;
        for (int i = 7; i >= 0; i--) bit_xfer(b[i], rb);
        bit_xfer(1'b1, ackbit);
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] d);
        logic rb;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(1'b1, rb);
            d[i] = rb;
        end
        bit_xfer(give_ack ? 1'b0 : 1'b1, rb);
    endtask

    task automatic release_byte(input logic [7:0] d, input logic aa);
        data_wr = d;
        data_we = 1'b1;
        aa_i    = aa;
        tick(1);
        data_we = 1'b0;
        si_clr  = 1'b1;
        tick(1);
        si_clr  = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 si", si_o, 0);
        chk("R1 status", status_o, 8'hF8);
        chk("R1 drive", {scl_oe, sda_oe}, 0);
    endtask

    task automatic t_full_read();
        logic a; logic [7:0] d;
        aa_i = 1'b1;
        bus_start();
        write_byte({OWN, 1'b1}, a);
        chk("R2 addr ack", a, 0);
        chk("R2 si", si_o, 1);
        chk("R2 status", status_o, 8'hA8);
        scl_m = 1'b1;
        tick(50);
        chk("R6 scl held", scl_line, 0);
        scl_m = 1'b0;
        release_byte(8'hA5, 1'b1);
        chk("R6 si cleared", si_o, 0);
        read_byte(1'b1, d);
        chk("R7 data msb first", d, 8'hA5);
        chk("R8 status", status_o, 8'hB8);
        chk("R8 si", si_o, 1);
        release_byte(8'h3C, 1'b0);
        read_byte(1'b1, d);
        chk("R8 second byte", d, 8'h3C);
        chk("R10 last acked", status_o, 8'hC8);
        release_byte(8'h00, 1'b1);
        read_byte(1'b1, d);
        chk("R10 after last", d, 8'hFF);
        chk("R10 no si", si_o, 0);
        bus_stop();
    endtask

    task automatic t_nack();
        logic a; logic [7:0] d;
        aa_i = 1'b1;
        bus_start();
        write_byte({OWN, 1'b1}, a);
        release_byte(8'h81, 1'b1);
        read_byte(1'b0, d);
        chk("R9 data", d, 8'h81);
        chk("R9 status", status_o, 8'hC0);
        release_byte(8'h00, 1'b1);
        read_byte(1'b1, d);
        chk("R9 reads ones", d, 8'hFF);
        bus_stop();
    endtask

    task automatic t_foreign();
        logic a;
        bus_start();
        write_byte({7'h13, 1'b1}, a);
        chk("R3 other addr nack", a, 1);
        chk("R3 other addr si", si_o, 0);
        bus_stop();
        bus_start();
        write_byte({OWN, 1'b0}, a);
        chk("R3 write nack", a, 1);
        chk("R3 write si", si_o, 0);
        bus_stop();
    endtask

    task automatic t_aa_gate();
        logic a;
        aa_i = 1'b0;
        bus_start();
        write_byte({OWN, 1'b1}, a);
        chk("R4 aa off nack", a, 1);
        chk("R4 aa off si", si_o, 0);
        bus_stop();
        chk("R11 idle after stop", {scl_oe, sda_oe}, 0);
        aa_i = 1'b1;
        bus_start();
        write_byte({OWN, 1'b1}, a);
        chk("R4 aa on ack", a, 0);
        chk("R4 aa on status", status_o, 8'hA8);
        release_byte(8'hF0, 1'b0);
        bus_stop_after_read();
    endtask

    task automatic bus_stop_after_read();
        logic [7:0] d;
        read_byte(1'b0, d);
        release_byte(8'h00, 1'b1);
        bus_stop();
    endtask

    task automatic t_arb();
        logic a;
        arb_lost_i = 1'b1;
        tick(1);
        arb_lost_i = 1'b0;
        bus_start();
        write_byte({OWN, 1'b1}, a);
        chk("R5 ack", a, 0);
        chk("R5 status", status_o, 8'hB0);
        release_byte(8'h11, 1'b1);
        bus_stop_after_read();
    endtask

    task automatic t_restart();
        logic a; logic [7:0] d;
        bus_start();
        write_byte({OWN, 1'b1}, a);
        release_byte(8'h5A, 1'b0);
        read_byte(1'b1, d);
        chk("R10 last data", d, 8'h5A);
        release_byte(8'h00, 1'b1);
        bus_start();
        write_byte({OWN, 1'b1}, a);
        chk("R11 restart ack", a, 0);
        chk("R11 restart status", status_o, 8'hA8);
        release_byte(8'h66, 1'b1);
        read_byte(1'b0, d);
        chk("R11 restart data", d, 8'h66);
        release_byte(8'h00, 1'b1);
        bus_stop();
    endtask

    initial begin
        tick(5);
        t_reset();
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_full_read();
        t_nack();
        t_foreign();
        t_aa_gate();
        t_arb();
        t_restart();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

endmodule